// File: doc/BRIEF.md
# Carry-Flag Arithmetic and Logic Unit

A purely combinational datapath unit for a 16-bit load/store processor. Each cycle it receives a 4-bit operation code, the current value of the destination register, the effective data value (the source register plus any operand word, already summed upstream), and the processor's zero, carry and sign flags. From these it produces a result word, a destination write-enable, and the next values of the three flags.

Subtraction works by adding the inverted operand. The carry flag is therefore a "not borrow" indication: it is 1 when no borrow occurred. Compare operations compute the same difference as subtraction but do not write it back. Rotate-right and byte swap operate on the effective data, not on the destination. Store, load and status-register transfer codes pass through this unit untouched. The surrounding pipeline handles register access, memory, predication and status transfers. The flag outputs can be fed straight back into the flag register every cycle, because operations that must not change a flag return its incoming value.

Top module: `alu16_core`

## Requirements
- R1: Code 0 returns the effective data. Codes 1, 2 and 3 return destination AND, OR and XOR effective data. All four assert the write-enable.
- R2: Code 4 returns destination + effective data, with carry-out as the new C. Code 5 also adds the incoming C. Both assert the write-enable.
- R3: Code 10 returns destination + ~effective data + 1. Code 11 returns destination + ~effective data + incoming C. The new C is the carry-out (1 means no borrow), and the write-enable is asserted.
- R4: Codes 12 and 13 produce the same result value and flags as codes 10 and 11, but hold the write-enable low.
- R5: Code 8 rotates right through carry. Result bit 15 becomes the incoming C, result bits 14..0 become effective data bits 15..1, and the new C becomes effective data bit 0. The write-enable is asserted.
- R6: Code 9 returns the bitwise inverse of the effective data and asserts the write-enable.
- R7: Code 14 returns the effective data with its low byte (bits 7..0) moved to bits 15..8 and its high byte moved to bits 7..0. The write-enable is asserted.
- R8: For every code except 6, 7 and 15, Z becomes 1 exactly when the 16-bit result is zero, and S becomes result bit 15.
- R9: Codes 0, 1, 2, 3, 9 and 14 return the incoming C unchanged.
- R10: Codes 6, 7 and 15 hold the write-enable low, return all three incoming flags unchanged, and return the effective data as the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operation code |
| rd_i | input | 16 | Destination register value |
| ed_i | input | 16 | Effective data value |
| z_i | input | 1 | Current zero flag |
| c_i | input | 1 | Current carry flag |
| s_i | input | 1 | Current sign flag |
| res_o | output | 16 | Result word |
| wr_o | output | 1 | Destination write-enable |
| z_o | output | 1 | Next zero flag |
| c_o | output | 1 | Next carry flag |
| s_o | output | 1 | Next sign flag |

## Verification
The bench builds the unit with its default data width of 16, the width the opcode semantics are defined for. At this width the bench can exercise the carry out of bit 15, the byte boundary between bits 7 and 8 that the swap depends on, and the sign bit. Directed vectors target the wrap of 0xFFFF + 1 to zero, borrow and no-borrow subtraction, subtract-with-carry chaining, and a rotate with carry set. A seeded random sweep over all sixteen codes, with random flag inputs, covers the mixes the directed vectors miss.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

    typedef enum logic [3:0] {
        OP_MOV  = 4'd0,
        OP_AND  = 4'd1,
        OP_OR   = 4'd2,
        OP_XOR  = 4'd3,
        OP_ADD  = 4'd4,
        OP_ADC  = 4'd5,
        OP_STO  = 4'd6,
        OP_LD   = 4'd7,
        OP_ROR  = 4'd8,
        OP_NOT  = 4'd9,
        OP_SUB  = 4'd10,
        OP_SBC  = 4'd11,
        OP_CMP  = 4'd12,
        OP_CMPC = 4'd13,
        OP_BSWP = 4'd14,
        OP_PSR  = 4'd15
    } alu_op_e;

    // carry-in source for the adder
    typedef enum logic [1:0] {
        CIN_ZERO  = 2'd0,
        CIN_ONE   = 2'd1,
        CIN_FLAG  = 2'd2
    } cin_sel_e;

    typedef struct packed {
        logic     inv_b;    // invert effective data into the adder
        cin_sel_e cin_sel;  // adder carry-in source
        logic     write;    // destination write-enable
        logic     upd_c;    // carry flag updated
        logic     upd_zs;   // zero and sign flags updated
    } alu_ctl_t;

endpackage

// File: rtl/alu16_decode.sv
module alu16_decode
    import alu16_pkg::*;
(
    input  logic [3:0] op_i,
    output alu_ctl_t   ctl_o
);

    alu_ctl_t ctl_d;

    always_comb begin
        ctl_d = '{inv_b: 1'b0, cin_sel: CIN_ZERO, write: 1'b1,
                  upd_c: 1'b0, upd_zs: 1'b1};
        case (alu_op_e'(op_i))
            OP_ADD:  ctl_d.upd_c = 1'b1;
            OP_ADC:  begin ctl_d.upd_c = 1'b1; ctl_d.cin_sel = CIN_FLAG; end
            OP_SUB:  begin ctl_d.upd_c = 1'b1; ctl_d.inv_b = 1'b1; ctl_d.cin_sel = CIN_ONE; end
            OP_SBC:  begin ctl_d.upd_c = 1'b1; ctl_d.inv_b = 1'b1; ctl_d.cin_sel = CIN_FLAG; end
            OP_CMP:  begin
                ctl_d.upd_c = 1'b1; ctl_d.inv_b = 1'b1;
                ctl_d.cin_sel = CIN_ONE; ctl_d.write = 1'b0;
            end
            OP_CMPC: begin
                ctl_d.upd_c = 1'b1; ctl_d.inv_b = 1'b1;
                ctl_d.cin_sel = CIN_FLAG; ctl_d.write = 1'b0;
            end
            OP_ROR:  ctl_d.upd_c = 1'b1;
            OP_STO, OP_LD, OP_PSR: begin
                ctl_d.write  = 1'b0;
                ctl_d.upd_zs = 1'b0;
            end
            default: ;
        endcase
    end

    assign ctl_o = ctl_d;

endmodule

// File: rtl/alu16_adder.sv
module alu16_adder
    import alu16_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         inv_b_i,
    input  cin_sel_e     cin_sel_i,
    input  logic         c_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);

    logic [W-1:0] b_eff_d;
    logic         cin_d;
    logic [W:0]   total_d;

    always_comb begin
        b_eff_d = inv_b_i ? ~b_i : b_i;
        case (cin_sel_i)
            CIN_ONE:  cin_d = 1'b1;
            CIN_FLAG: cin_d = c_i;
            default:  cin_d = 1'b0;
        endcase
        total_d = {1'b0, a_i} + {1'b0, b_eff_d} + {{W{1'b0}}, cin_d};
    end

    assign sum_o  = total_d[W-1:0];
    assign cout_o = total_d[W];

endmodule

// File: rtl/alu16_bitops.sv
module alu16_bitops #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         c_i,
    output logic [W-1:0] and_o,
    output logic [W-1:0] or_o,
    output logic [W-1:0] xor_o,
    output logic [W-1:0] not_o,
    output logic [W-1:0] swap_o,
    output logic [W-1:0] ror_o,
    output logic         ror_c_o
);

    localparam int HALF = W / 2;

    assign and_o   = a_i & b_i;
    assign or_o    = a_i | b_i;
    assign xor_o   = a_i ^ b_i;
    assign not_o   = ~b_i;
    assign ror_o   = {c_i, b_i[W-1:1]};
    assign ror_c_o = b_i[0];

    // exchange the two halves of the effective data
    for (genvar g = 0; g < HALF; g++) begin : g_swap
        assign swap_o[g + HALF] = b_i[g];
        assign swap_o[g]        = b_i[g + HALF];
    end

endmodule

// File: rtl/alu16_core.sv
module alu16_core
    import alu16_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [3:0]   op_i,
    input  logic [W-1:0] rd_i,
    input  logic [W-1:0] ed_i,
    input  logic         z_i,
    input  logic         c_i,
    input  logic         s_i,
    output logic [W-1:0] res_o,
    output logic         wr_o,
    output logic         z_o,
    output logic         c_o,
    output logic         s_o
);

    typedef struct packed {
        logic [W-1:0] res;
        logic         wr;
        logic         z;
        logic         c;
        logic         s;
    } alu_out_t;

    alu_ctl_t     ctl;
    logic [W-1:0] sum, and_v, or_v, xor_v, not_v, swap_v, ror_v;
    logic         cout, ror_c;
    alu_out_t     out_d;

    alu16_decode u_decode (
        .op_i  (op_i),
        .ctl_o (ctl)
    );

    alu16_adder #(.W(W)) u_adder (
        .a_i       (rd_i),
        .b_i       (ed_i),
        .inv_b_i   (ctl.inv_b),
        .cin_sel_i (ctl.cin_sel),
        .c_i       (c_i),
        .sum_o     (sum),
        .cout_o    (cout)
    );

    alu16_bitops #(.W(W)) u_bitops (
        .a_i     (rd_i),
        .b_i     (ed_i),
        .c_i     (c_i),
        .and_o   (and_v),
        .or_o    (or_v),
        .xor_o   (xor_v),
        .not_o   (not_v),
        .swap_o  (swap_v),
        .ror_o   (ror_v),
        .ror_c_o (ror_c)
    );

    always_comb begin
        out_d.res = ed_i;
        case (alu_op_e'(op_i))
            OP_AND:  out_d.res = and_v;
            OP_OR:   out_d.res = or_v;
            OP_XOR:  out_d.res = xor_v;
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP, OP_CMPC:
                     out_d.res = sum;
            OP_ROR:  out_d.res = ror_v;
            OP_NOT:  out_d.res = not_v;
            OP_BSWP: out_d.res = swap_v;
            default: out_d.res = ed_i;
        endcase
        out_d.wr = ctl.write;
        if (ctl.upd_c)
            out_d.c = (alu_op_e'(op_i) == OP_ROR) ? ror_c : cout;
        else
            out_d.c = c_i;
        out_d.z = ctl.upd_zs ? (out_d.res == '0) : z_i;
        out_d.s = ctl.upd_zs ? out_d.res[W-1]    : s_i;
    end

    assign res_o = out_d.res;
    assign wr_o  = out_d.wr;
    assign z_o   = out_d.z;
    assign c_o   = out_d.c;
    assign s_o   = out_d.s;

endmodule

// File: rtl/alu16_checker.sv
module alu16_checker #(
    parameter int W = 16
) (
    input logic [3:0]   op_i,
    input logic [W-1:0] rd_i,
    input logic [W-1:0] ed_i,
    input logic         z_i,
    input logic         c_i,
    input logic         s_i,
    input logic [W-1:0] res_o,
    input logic         wr_o,
    input logic         z_o,
    input logic         c_o,
    input logic         s_o
);

    localparam int HALF = W / 2;

    logic passthru, keeps_c, is_cmp;

    always_comb begin
        passthru = (op_i == 4'd6) || (op_i == 4'd7) || (op_i == 4'd15);
        keeps_c  = (op_i <= 4'd3) || (op_i == 4'd9) || (op_i == 4'd14);
        is_cmp   = (op_i == 4'd12) || (op_i == 4'd13);

        if (is_cmp)
            p_cmp_no_write_r4: assert (!wr_o) else $error("compare wrote destination");
        if (passthru)
            p_passthru_frozen_r10: assert (!wr_o && z_o == z_i && c_o == c_i
                                           && s_o == s_i && res_o == ed_i)
                else $error("pass-through code altered state");
        if (!passthru)
            p_zs_track_result_r8: assert (z_o == (res_o == '0) && s_o == res_o[W-1])
                else $error("Z/S disagree with result");
        if (keeps_c)
            p_carry_held_r9: assert (c_o == c_i) else $error("carry changed");
        if (op_i == 4'd8)
            p_ror_through_c_r5: assert (c_o == ed_i[0] && res_o[W-1] == c_i)
                else $error("rotate carry path wrong");
        if (op_i == 4'd14)
            p_swap_halves_r7: assert (res_o[W-1:HALF] == ed_i[HALF-1:0]
                                      && res_o[HALF-1:0] == ed_i[W-1:HALF])
                else $error("byte swap wrong");
        if (op_i == 4'd9)
            p_invert_r6: assert ((res_o ^ ed_i) == '1) else $error("invert wrong");
        if (op_i == 4'd4)
            p_add_r2: assert ({c_o, res_o} == {1'b0, rd_i} + {1'b0, ed_i})
                else $error("add wrong");
    end

endmodule

bind alu16_core alu16_checker #(.W(W)) u_alu16_checker (
    .op_i  (op_i),
    .rd_i  (rd_i),
    .ed_i  (ed_i),
    .z_i   (z_i),
    .c_i   (c_i),
    .s_i   (s_i),
    .res_o (res_o),
    .wr_o  (wr_o),
    .z_o   (z_o),
    .c_o   (c_o),
    .s_o   (s_o)
);

// File: tb/test_alu16_core.sv
`timescale 1ns/1ps
module test_alu16_core;

    logic        clk = 1'b0;
    logic [3:0]  op;
    logic [15:0] rd, ed, res;
    logic        zi, ci, si, wr, zo, co, so;
    int          total = 0;
    int          bad   = 0;
    bit          done  = 1'b0;

    always #5 clk = ~clk;

    alu16_core #(.W(16)) i_alu16_core (
        .op_i (op), .rd_i (rd), .ed_i (ed),
        .z_i (zi), .c_i (ci), .s_i (si),
        .res_o (res), .wr_o (wr), .z_o (zo), .c_o (co), .s_o (so)
    );

    // expected {wr, z, c, s, res}
    function automatic logic [19:0] model(input logic [3:0] o, input logic [15:0] a,
                                          input logic [15:0] b, input logic z,
                                          input logic c, input logic s);
        logic [16:0] t;
        logic [15:0] r;
        logic        w, cn, zs;
        r = b; w = 1'b1; cn = c; zs = 1'b1;
        case (o)
            4'd0:  r = b;
            4'd1:  r = a & b;
            4'd2:  r = a | b;
            4'd3:  r = a ^ b;
            4'd4:  begin t = {1'b0, a} + {1'b0, b}; r = t[15:0]; cn = t[16]; end
            4'd5:  begin t = {1'b0, a} + {1'b0, b} + {16'd0, c}; r = t[15:0]; cn = t[16]; end
            4'd8:  begin r = {c, b[15:1]}; cn = b[0]; end
            4'd9:  r = ~b;
            4'd10, 4'd12: begin t = {1'b0, a} + {1'b0, ~b} + 17'd1; r = t[15:0]; cn = t[16]; end
            4'd11, 4'd13: begin t = {1'b0, a} + {1'b0, ~b} + {16'd0, c}; r = t[15:0]; cn = t[16]; end
            4'd14: r = {b[7:0], b[15:8]};
            default: begin w = 1'b0; zs = 1'b0; end
        endcase
        if (o == 4'd12 || o == 4'd13) w = 1'b0;
        return {w, zs ? (r == 16'd0) : z, cn, zs ? r[15] : s, r};
    endfunction

    function automatic string req_res(input logic [3:0] o);
        case (o)
            4'd0, 4'd1, 4'd2, 4'd3: return "R1";
            4'd4, 4'd5:             return "R2";
            4'd10, 4'd11:           return "R3";
            4'd12, 4'd13:           return "R4";
            4'd8:                   return "R5";
            4'd9:                   return "R6";
            4'd14:                  return "R7";
            default:                return "R10";
        endcase
    endfunction

    function automatic string req_c(input logic [3:0] o);
        case (o)
            4'd0, 4'd1, 4'd2, 4'd3, 4'd9, 4'd14: return "R9";
            4'd6, 4'd7, 4'd15:                   return "R10";
            default:                              return req_res(o);
        endcase
    endfunction

    task automatic apply(input logic [3:0] o, input logic [15:0] a, input logic [15:0] b,
                         input logic z, input logic c, input logic s);
        logic [19:0] e;
        string       rq;
        @(posedge clk);
        op = o; rd = a; ed = b; zi = z; ci = c; si = s;
        @(negedge clk);
        e = model(o, a, b, z, c, s);
        total++;
        rq = req_res(o);
        if ({wr, res} != {e[19], e[15:0]}) begin
            bad++;
            $display("FAIL %s op=%0d wr/res got %b/%h exp %b/%h", rq, o, wr, res, e[19], e[15:0]);
        end
        total++;
        rq = (o == 4'd6 || o == 4'd7 || o == 4'd15) ? "R10" : "R8";
        if ({zo, so} != {e[18], e[16]}) begin
            bad++;
            $display("FAIL %s op=%0d z/s got %b%b exp %b%b", rq, o, zo, so, e[18], e[16]);
        end
        total++;
        rq = req_c(o);
        if (co != e[17]) begin
            bad++;
            $display("FAIL %s op=%0d carry got %b exp %b", rq, o, co, e[17]);
        end
    endtask

    initial begin
        void'($urandom(32'd4242));
        op = 4'd0; rd = '0; ed = '0; zi = 1'b0; ci = 1'b0; si = 1'b0;
        // idle inputs: MOV of zero (R1, R8)
        apply(4'd0, 16'h0000, 16'h0000, 1'b0, 1'b1, 1'b0);
        // R1 logic patterns
        apply(4'd1, 16'hF0F0, 16'h3C3C, 1'b0, 1'b0, 1'b0);
        apply(4'd2, 16'h8000, 16'h0001, 1'b0, 1'b1, 1'b0);
        apply(4'd3, 16'hA5A5, 16'hA5A5, 1'b0, 1'b0, 1'b1);
        // R2 wrap to zero, carry chain
        apply(4'd4, 16'hFFFF, 16'h0001, 1'b0, 1'b0, 1'b1);
        apply(4'd5, 16'hFFFF, 16'h0000, 1'b0, 1'b1, 1'b0);
        apply(4'd5, 16'h7FFF, 16'h0000, 1'b1, 1'b1, 1'b0);
        // R3 no-borrow and borrow
        apply(4'd10, 16'h1234, 16'h1234, 1'b0, 1'b0, 1'b1);
        apply(4'd10, 16'h0000, 16'h0001, 1'b1, 1'b1, 1'b0);
        apply(4'd11, 16'h0005, 16'h0005, 1'b0, 1'b0, 1'b0);
        // R4 compare
        apply(4'd12, 16'h0003, 16'h0009, 1'b1, 1'b1, 1'b0);
        apply(4'd13, 16'h8000, 16'h7FFF, 1'b0, 1'b1, 1'b0);
        // R5 rotate with carry set / clear
        apply(4'd8, 16'h0000, 16'h0001, 1'b0, 1'b1, 1'b0);
        apply(4'd8, 16'hFFFF, 16'h0001, 1'b1, 1'b0, 1'b1);
        // R6, R7, R9
        apply(4'd9, 16'h0000, 16'hFFFF, 1'b0, 1'b1, 1'b1);
        apply(4'd14, 16'h0000, 16'h00FF, 1'b1, 1'b0, 1'b0);
        apply(4'd14, 16'h0000, 16'h1200, 1'b0, 1'b1, 1'b0);
        // R10 pass-through
        apply(4'd6, 16'h1111, 16'h0000, 1'b0, 1'b1, 1'b1);
        apply(4'd7, 16'h2222, 16'h8000, 1'b1, 1'b0, 1'b0);
        apply(4'd15, 16'h3333, 16'h0042, 1'b1, 1'b1, 1'b1);
        // random sweep across all codes
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] a, b;
            logic [3:0]  o;
            logic [2:0]  f;
            o = 4'($urandom_range(0, 15));
            a = 16'($urandom);
            b = ($urandom_range(0, 7) == 0) ? a : 16'($urandom);
            f = 3'($urandom);
            apply(o, a, b, f[2], f[1], f[0]);
        end
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule